// File: doc/BRIEF.md
# Variable-Length Register Command Receiver

This block is the serial front end of an instrument's control path. A host drives it as an SPI slave in mode 0. The first byte of every command names a target register. The block looks up how many payload bytes belong to that register and collects exactly that many. It then raises a single write strobe, which carries the register number and the payload assembled most-significant byte first. The strobe and data appear in the system clock domain. The serial lines are brought into that domain through synchronizers.

The receiver does not time out. If a command arrives short, the block keeps waiting for the rest of it, even across chip-select gaps. Only the synchronous reset abandons a partial command.

In the other direction, system logic offers an 8-byte reply on the response load port. The block shifts that reply out on MISO, most-significant bit first. It refuses a new reply until the host has clocked out all 64 bits of the current one.

Top module: `reg_cmd_rx`

## Requirements
- R1: The first complete byte after reset or after a finished command is taken as a register number. Its payload length is: 0x01 and 0x02 take 1 byte, 0x20 takes 1 byte, 0x11 and 0x18 take 3 bytes, and 0x0A and 0x10 take 7 bytes.
- R2: Payload bytes are shifted in MSB first, and each byte arrives MSB first. `wr_data` holds the payload right-aligned, with the last byte in [7:0]. All bits above the payload length are zero.
- R3: `wr_valid` pulses high for exactly one system clock after the last payload byte, with `wr_addr` equal to the register number. No strobe appears before the last byte.
- R4: Any register number outside the R1 list has zero payload bytes and never produces a strobe. The byte after it is treated as a new register number.
- R5: Raising `cs_n` in the middle of a payload does not abandon the command. Bytes sent in later chip-select windows continue filling the same payload.
- R6: Raising `cs_n` discards a partially shifted byte. The next byte starts fresh at bit 7.
- R7: The synchronous reset `rst` clears any partial command and any pending reply. After reset `wr_valid`=0, `miso`=0 and `rsp_ready`=1.
- R8: When `rsp_ready`=1, a high `rsp_load` captures `rsp_data` and drops `rsp_ready`. The reply then appears on `miso` MSB first, advancing one bit per SCLK rising edge while `cs_n` is low.
- R9: While a reply is pending, `rsp_load` is ignored. `rsp_ready` returns to 1 and `miso` to 0 only after 64 SCLK rising edges have read the reply out.
- R10: Several complete commands can follow each other within one chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | SPI clock from host |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Chip select, active low |
| miso | output | 1 | Serial reply data to host |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register number of the write |
| wr_data | output | 56 | Right-aligned payload of the write |
| rsp_load | input | 1 | Offer a reply |
| rsp_data | input | 64 | Reply to send |
| rsp_ready | output | 1 | Reply buffer empty |

## Verification
Some properties are checked on every cycle by assertions:
- the write strobe lasts a single cycle;
- it only names a known register;
- its data never has bits set above that register's length;
- a pending reply stays frozen between SCLK edges and is only filled through `rsp_load`;
- reset empties the receiver.

The bench scenarios cover behaviour that spans whole transactions:
- the byte order of each payload length;
- the stall across chip-select gaps;
- the skip of unknown registers;
- the dropping of partial bytes;
- the refusal of a second reply before all 64 bits are read.

// File: rtl/reg_cmd_rx.sv
module reg_cmd_rx #(
  parameter int SYNC  = 2,
  parameter int DMAX  = 7,
  parameter int RBYTE = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic                  cs_n,
  output logic                  miso,
  output logic                  wr_valid,
  output logic [7:0]            wr_addr,
  output logic [8*DMAX-1:0]     wr_data,
  input  logic                  rsp_load,
  input  logic [8*RBYTE-1:0]    rsp_data,
  output logic                  rsp_ready
);
  localparam int DW  = 8 * DMAX;
  localparam int RW  = 8 * RBYTE;
  localparam int LW  = $clog2(DMAX + 1);
  localparam int RCW = $clog2(RW);

  function automatic logic [LW-1:0] plen(input logic [7:0] a);
    case (a)
      8'h01, 8'h02, 8'h20: plen = LW'(1);
      8'h11, 8'h18:        plen = LW'(3);
      8'h0A, 8'h10:        plen = LW'(7);
      default:             plen = '0;
    endcase
  endfunction

  logic [SYNC:0]   sclk_q;
  logic [SYNC-1:0] cs_q, mosi_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
    end
  end

  wire       cs_act = ~cs_q[SYNC-1];
  wire       sbit   = sclk_q[SYNC-1] & ~sclk_q[SYNC] & cs_act;

  logic [6:0]    sh;
  logic [2:0]    bcnt;
  logic          have_addr;
  logic [LW-1:0] left;
  logic [DW-1:0] acc;

  wire [7:0] byte_in   = {sh, mosi_q[SYNC-1]};
  wire       byte_done = sbit && bcnt == 3'd7;

  assign wr_data = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bcnt      <= '0;
      have_addr <= 1'b0;
      left      <= '0;
      acc       <= '0;
      wr_addr   <= '0;
      wr_valid  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (!cs_act) bcnt <= '0;
      else if (sbit) begin
        sh   <= byte_in[6:0];
        bcnt <= bcnt + 3'd1;
      end
      if (byte_done) begin
        if (!have_addr) begin
          if (plen(byte_in) != '0) begin
            have_addr <= 1'b1;
            wr_addr   <= byte_in;
            left      <= plen(byte_in);
            acc       <= '0;
          end
        end else begin
          acc  <= {acc[DW-9:0], byte_in};
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            have_addr <= 1'b0;
            wr_valid  <= 1'b1;
          end
        end
      end
    end
  end

  logic [RW-1:0]  rsp_sh;
  logic           rsp_full;
  logic [RCW-1:0] rsp_cnt;

  assign miso      = rsp_full & rsp_sh[RW-1];
  assign rsp_ready = ~rsp_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_sh   <= '0;
      rsp_full <= 1'b0;
      rsp_cnt  <= '0;
    end else if (!rsp_full) begin
      if (rsp_load) begin
        rsp_sh   <= rsp_data;
        rsp_full <= 1'b1;
        rsp_cnt  <= '0;
      end
    end else if (sbit) begin
      rsp_sh  <= {rsp_sh[RW-2:0], 1'b0};
      rsp_cnt <= rsp_cnt + RCW'(1);
      if (rsp_cnt == RCW'(RW - 1)) rsp_full <= 1'b0;
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  a_r4_known_only: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> plen(wr_addr) != '0);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_data >> {plen(wr_addr), 3'b000}) == '0);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_full && !sbit) |=> rsp_full && $stable(rsp_sh));
  a_r8_fill_by_load: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_full) |-> $past(rsp_load));
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> !wr_valid && !have_addr && bcnt == 3'd0 && !rsp_full);
endmodule

// File: tb/reg_cmd_rx_tb_top.sv
module reg_cmd_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, wr_valid, rsp_load = 1'b0, rsp_ready;
  logic [7:0]  wr_addr;
  logic [55:0] wr_data;
  logic [63:0] rsp_data = '0;

  int checks = 0, errors = 0, strobes = 0;
  logic [63:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  reg_cmd_rx dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_load(rsp_load), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      strobes++;
      if (exp_q.size() == 0) chk("R4 unexpected strobe", {wr_addr, wr_data}, 64'hX);
      else chk("R3 strobe", {wr_addr, wr_data}, exp_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on();  cs_n = 1'b0; tick(HALF); endtask
  task automatic cs_off(); tick(HALF); cs_n = 1'b1; tick(2*HALF); endtask

  task automatic send(input logic [7:0] a, input int n, input logic [55:0] d);
    logic [7:0] r;
    xfer(a, r);
    for (int i = n - 1; i >= 0; i--) xfer(d[8*i +: 8], r);
  endtask

  task automatic cmd(input logic [7:0] a, input int n, input logic [55:0] d);
    exp_q.push_back({a, d});
    cs_on(); send(a, n, d); cs_off();
  endtask

  task automatic load(input logic [63:0] v);
    rsp_data = v; rsp_load = 1'b1; tick(1); rsp_load = 1'b0; tick(1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int base;
    tick(4); rst = 1'b0; tick(2);
    chk("R7 reset wr_valid", wr_valid, 0);
    chk("R7 reset miso", miso, 0);
    chk("R7 reset rsp_ready", rsp_ready, 1);

    // R1 R2 R3 each length class
    cmd(8'h01, 1, 56'hA5);
    cmd(8'h11, 3, 56'h123456);
    cmd(8'h10, 7, 56'hFEDCBA98765432);
    cmd(8'h0A, 7, 56'h00000102030405);
    cmd(8'h18, 3, 56'h3FFF01);
    cmd(8'h02, 1, 56'h81);
    cmd(8'h20, 1, 56'h05);

    // R5 stall across chip-select gap
    base = strobes;
    exp_q.push_back({8'h10, 56'h11223344556677});
    cs_on(); send(8'h10, 0, 0);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); cs_off();
    chk("R5 no strobe while short", strobes - base, 0);
    cs_on(); xfer(8'h44, r); xfer(8'h55, r); xfer(8'h66, r); xfer(8'h77, r); cs_off();
    chk("R5 strobe after completion", strobes - base, 1);

    // R4 unknown register skipped
    base = strobes;
    exp_q.push_back({8'h02, 56'h7E});
    cs_on(); xfer(8'h55, r); send(8'h02, 1, 56'h7E); cs_off();
    chk("R4 one strobe only", strobes - base, 1);

    // R6 partial byte dropped on cs_n high
    cs_on();
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    cs_off();
    cmd(8'h01, 1, 56'h3C);

    // R7 reset abandons a partial command
    cs_on(); send(8'h10, 0, 0); xfer(8'hAA, r); xfer(8'hBB, r); cs_off();
    rst = 1'b1; tick(2); rst = 1'b0; tick(2);
    cmd(8'h01, 1, 56'h99);

    // R10 back to back inside one window
    exp_q.push_back({8'h01, 56'h11});
    exp_q.push_back({8'h11, 56'hAABBCC});
    cs_on(); send(8'h01, 1, 56'h11); send(8'h11, 3, 56'hAABBCC); cs_off();

    // R8 R9 reply readout
    load(64'h0123456789ABCDEF);
    chk("R8 rsp_ready low after load", rsp_ready, 0);
    chk("R8 first bit on miso", miso, 0);
    cs_on();
    for (int b = 7; b >= 4; b--) begin
      xfer(8'h00, r);
      chk("R8 reply byte", r, 64'(8'(64'h0123456789ABCDEF >> (8*b))));
    end
    cs_off();
    load(64'hFFFFFFFFFFFFFFFF);
    chk("R9 busy after ignored load", rsp_ready, 0);
    cs_on();
    for (int b = 3; b >= 0; b--) begin
      xfer(8'h00, r);
      chk("R9 reply byte kept", r, 64'(8'(64'h0123456789ABCDEF >> (8*b))));
    end
    cs_off();
    chk("R9 ready after 64 bits", rsp_ready, 1);
    chk("R9 miso idle", miso, 0);
    load(64'h8000000000000000);
    chk("R9 new reply accepted", rsp_ready, 0);
    cs_on(); xfer(8'h00, r); cs_off();
    chk("R8 second reply first byte", r, 64'h80);

    tick(20);
    chk("R3 all expected strobes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule